// File: doc/BRIEF.md
# Burst Read Ready Generator

This block drives the ready/wait status pin of a memory that can deliver data in synchronous bursts. While a burst read is in progress, it tells the host in which clock cycles a valid word is on the bus and in which cycles the host must wait. Wait cycles come from three sources. The first is the initial access latency after the burst start strobe. The second is a single stall each time the burst crosses the internal 64-word boundary. The third is a stall on every third clock when the system clock runs slowly.

Outside a burst read the pin simply reports "ready". When the chip is deselected, a separate output-enable lets the pin float. The block keeps its own copy of the burst word address and advances it on every clock in which a word is handed over. It compares the low six address bits against the boundary offset. A new burst is started by the address-valid strobe, which loads the start address and the latency setting.

Top module: `burst_ready_gen`

## Requirements
- R1: When a burst starts (chip_en, burst_mode and addr_valid high at a clock edge) with latency setting L, rdy is low for the next max(L,2) cycles while out_en is high. Settings 0 and 1 count as 2. The first data cycle follows.
- R2: When a word is handed over at an address whose low six bits equal 62 (3Eh), the burst moves to offset 63 and rdy is low for exactly one cycle. This holds in every 64-word window.
- R3: With slow_clk high, after the latency has elapsed a phase counter runs 0,1,2 on every clock. rdy is low whenever the phase is 2.
- R4: With chip_en high and out_en low, rdy is 1 and rdy_oe is 1. The latency and slow-clock phase keep counting, and the address does not advance.
- R5: With chip_en low, rdy_oe is 0 and rdy is 0. The burst is aborted, and the latency, phase and boundary state are cleared.
- R6: With burst_mode low and chip_en high, rdy is 1 at all times. Dropping burst_mode also ends any burst.
- R7: In a burst data cycle with out_en high and no wait cause, rdy is 1 and the word address advances by one.
- R8: While rst is high, and after it until the next burst start, rdy equals chip_en and rdy_oe equals chip_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| burst_mode | input | 1 | 1 = synchronous burst reads, 0 = asynchronous |
| addr_valid | input | 1 | Burst start strobe |
| start_addr | input | ADDR_W | Burst start word address |
| lat_sel | input | LAT_W | Initial access latency in clocks |
| slow_clk | input | 1 | Slow-clock mode, inserts a wait every third clock |
| rdy | output | 1 | Ready level (1 = word valid) |
| rdy_oe | output | 1 | Ready pin drive enable (0 = high impedance) |

## Verification
A wrong address count or a lost boundary flag shows up as a missing or extra low cycle on rdy. This is visible no later than the next crossing of offset 62, which is at most 64 data cycles away. A slow-clock phase that is off by one, or a latency that is miscounted, moves the first low or high cycle of rdy by a clock. A per-cycle reference comparison therefore catches it in the very cycle it occurs. Abort and reset errors show as rdy staying low after a new select without a start strobe.

// File: rtl/rdy_pkg.sv
package rdy_pkg;

    typedef struct packed {
        logic lat;
        logic bnd;
        logic slow;
    } wait_src_t;

    function automatic logic any_wait(input wait_src_t w);
        return w.lat | w.bnd | w.slow;
    endfunction

endpackage

// File: rtl/lat_counter.sv
module lat_counter #(
    parameter int LAT_W   = 3,
    parameter int LAT_MIN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [LAT_W-1:0] lat_val,
    output logic             busy
);
    localparam logic [LAT_W-1:0] MIN_V = LAT_W'(LAT_MIN);

    logic [LAT_W-1:0] cnt_q;
    logic [LAT_W-1:0] load_v;

    assign load_v = (lat_val < MIN_V) ? MIN_V : lat_val;
    assign busy   = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_v;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/slow_phase.sv
module slow_phase #(
    parameter int SLOW_DIV = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    input  logic run,
    output logic phase_last
);
    localparam int CNT_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOW_DIV - 1);

    logic [CNT_W-1:0] ph_q;

    assign phase_last = (ph_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || load) begin
            ph_q <= '0;
        end else if (run) begin
            ph_q <= phase_last ? '0 : ph_q + 1'b1;
        end
    end
endmodule

// File: rtl/burst_addr.sv
module burst_addr #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    input  logic              consume,
    output logic              bnd_wait
);
    localparam logic [WIN_W-1:0] BND_OFF = WIN_W'((1 << WIN_W) - 2);

    logic [ADDR_W-1:0] addr_q;
    logic              bnd_q;
    logic              at_edge;

    assign at_edge  = (addr_q[WIN_W-1:0] == BND_OFF);
    assign bnd_wait = bnd_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            addr_q <= '0;
            bnd_q  <= 1'b0;
        end else if (load) begin
            addr_q <= load_addr;
            bnd_q  <= 1'b0;
        end else begin
            if (advance) begin
                addr_q <= addr_q + 1'b1;
            end
            if (advance && at_edge) begin
                bnd_q <= 1'b1;
            end else if (consume) begin
                bnd_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/burst_ready_gen.sv
module burst_ready_gen #(
    parameter int ADDR_W   = 16,
    parameter int WIN_W    = 6,
    parameter int LAT_W    = 3,
    parameter int LAT_MIN  = 2,
    parameter int SLOW_DIV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              out_en,
    input  logic              burst_mode,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LAT_W-1:0]  lat_sel,
    input  logic              slow_clk,
    output logic              rdy,
    output logic              rdy_oe
);
    import rdy_pkg::*;

    logic      active_q;
    logic      clr;
    logic      load;
    logic      lat_busy;
    logic      slow_last;
    logic      bnd_wait;
    logic      in_data;
    logic      stall;
    logic      advance;
    logic      consume;
    wait_src_t wsrc;

    assign clr     = !chip_en || !burst_mode;
    assign load    = chip_en && burst_mode && addr_valid;
    assign in_data = active_q && !lat_busy;

    always_comb begin
        wsrc.lat  = lat_busy;
        wsrc.bnd  = bnd_wait;
        wsrc.slow = slow_clk && slow_last && in_data;
    end

    assign stall   = !clr && active_q && out_en && any_wait(wsrc);
    assign advance = !clr && in_data && out_en && !stall;
    assign consume = in_data && out_en;

    assign rdy    = chip_en && !stall;
    assign rdy_oe = chip_en;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active_q <= 1'b0;
        end else if (load) begin
            active_q <= 1'b1;
        end
    end

    lat_counter #(.LAT_W(LAT_W), .LAT_MIN(LAT_MIN)) u_lat (
        .clk     (clk),
        .rst     (rst),
        .clear   (clr),
        .load    (load),
        .lat_val (lat_sel),
        .busy    (lat_busy)
    );

    slow_phase #(.SLOW_DIV(SLOW_DIV)) u_slow (
        .clk        (clk),
        .rst        (rst),
        .clear      (clr),
        .load       (load),
        .run        (in_data),
        .phase_last (slow_last)
    );

    burst_addr #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .clear     (clr),
        .load      (load),
        .load_addr (start_addr),
        .advance   (advance),
        .consume   (consume),
        .bnd_wait  (bnd_wait)
    );
endmodule

// File: rtl/burst_ready_gen_chk.sv
module burst_ready_gen_chk (
    input logic clk,
    input logic rst,
    input logic chip_en,
    input logic out_en,
    input logic burst_mode,
    input logic addr_valid,
    input logic rdy,
    input logic rdy_oe
);
    a_r5_float_when_deselected: assert property (@(posedge clk) disable iff (rst)
        !chip_en |-> (!rdy_oe && !rdy));

    a_r4_ready_without_oe: assert property (@(posedge clk) disable iff (rst)
        (chip_en && !out_en) |-> (rdy && rdy_oe));

    a_r6_async_always_ready: assert property (@(posedge clk) disable iff (rst)
        (chip_en && !burst_mode) |-> rdy);

    a_r1_first_cycle_waits: assert property (@(posedge clk) disable iff (rst)
        (chip_en && burst_mode && addr_valid) |=> (!rdy || !(chip_en && burst_mode && out_en)));
endmodule

bind burst_ready_gen burst_ready_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .chip_en    (chip_en),
    .out_en     (out_en),
    .burst_mode (burst_mode),
    .addr_valid (addr_valid),
    .rdy        (rdy),
    .rdy_oe     (rdy_oe)
);

// File: tb/burst_ready_gen_test.sv
module burst_ready_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_en = 1'b0;
    logic        out_en = 1'b0;
    logic        burst_mode = 1'b0;
    logic        addr_valid = 1'b0;
    logic [15:0] start_addr = '0;
    logic [2:0]  lat_sel = '0;
    logic        slow_clk = 1'b0;
    logic        rdy;
    logic        rdy_oe;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit checking = 1'b0;

    // behavioural reference state
    int m_active = 0, m_lat = 0, m_addr = 0, m_bnd = 0, m_slow = 0;

    always #10 clk = ~clk;

    burst_ready_gen uut (
        .clk(clk), .rst(rst), .chip_en(chip_en), .out_en(out_en),
        .burst_mode(burst_mode), .addr_valid(addr_valid),
        .start_addr(start_addr), .lat_sel(lat_sel), .slow_clk(slow_clk),
        .rdy(rdy), .rdy_oe(rdy_oe)
    );

    function automatic bit model_wait();
        return chip_en && burst_mode && (m_active != 0) && out_en &&
               ((m_lat > 0) || (m_bnd != 0) || (slow_clk && m_lat == 0 && m_slow == 2));
    endfunction

    always @(posedge clk) begin
        bit w;
        cycles++;
        w = model_wait();
        if (rst || !chip_en || !burst_mode) begin
            m_active = 0; m_lat = 0; m_addr = 0; m_bnd = 0; m_slow = 0;
        end else if (addr_valid) begin
            m_active = 1; m_lat = (lat_sel < 2) ? 2 : int'(lat_sel);
            m_addr = int'(start_addr); m_bnd = 0; m_slow = 0;
        end else if (m_active != 0) begin
            if (m_lat > 0) begin
                m_lat--;
            end else begin
                m_slow = (m_slow + 1) % 3;
                if (out_en && !w) begin
                    m_bnd = (m_addr % 64 == 62) ? 1 : 0;
                    m_addr = (m_addr + 1) % 65536;
                end else if (out_en) begin
                    m_bnd = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            bit exp_rdy;
            string tag;
            exp_rdy = chip_en && !model_wait();
            if (!chip_en) tag = "R5";
            else if (!burst_mode) tag = "R6";
            else if (!out_en) tag = "R4";
            else if (m_active != 0 && m_lat > 0) tag = "R1";
            else if (m_bnd != 0) tag = "R2";
            else if (m_active != 0 && slow_clk) tag = "R3";
            else tag = "R7";
            tests++;
            if (rdy !== exp_rdy || rdy_oe !== chip_en) begin
                fails++;
                $display("FAIL %s cycle %0d: rdy=%b rdy_oe=%b expected rdy=%b rdy_oe=%b",
                         tag, cycles, rdy, rdy_oe, exp_rdy, chip_en);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
        end
    endtask

    task automatic start_burst(input int a, input int l, input bit slow);
        @(negedge clk); #2;
        chip_en = 1; burst_mode = 1; out_en = 1; slow_clk = slow;
        start_addr = 16'(a); lat_sel = 3'(l); addr_valid = 1;
        @(negedge clk); #2;
        addr_valid = 0;
    endtask

    initial begin
        // R8: reset state with chip selected
        chip_en = 1;
        idle(2);
        tests++;
        if (rdy !== 1'b1 || rdy_oe !== 1'b1) begin
            fails++;
            $display("FAIL R8 reset: rdy=%b rdy_oe=%b expected 1 1", rdy, rdy_oe);
        end
        rst = 0;
        checking = 1;
        idle(3);
        // R6: asynchronous mode
        out_en = 1; idle(4);
        // R1, R7: plain burst, latency 4
        start_burst(16'h0010, 4, 0); idle(10);
        // R2: boundary crossing in window 0, latency clamp 0 -> 2
        start_burst(16'h003A, 0, 0); idle(12);
        // R2: boundary in a higher window, latency 7
        start_burst(16'h047C, 7, 0); idle(16);
        // R3: slow clock with boundary
        start_burst(16'h00BB, 3, 1); idle(20);
        // R4: out_en low mid burst, including over the boundary offset
        start_burst(16'h013C, 2, 0); idle(3);
        out_en = 0; idle(4); out_en = 1; idle(6);
        out_en = 0; idle(2); out_en = 1; idle(4);
        // R5: abort then reselect without a new start
        start_burst(16'h0000, 5, 1); idle(2);
        chip_en = 0; idle(3); chip_en = 1; idle(4);
        // R6: dropping burst_mode ends burst
        start_burst(16'h023D, 2, 1); idle(4);
        burst_mode = 0; idle(3); burst_mode = 1; idle(3);
        // R1: restart during a running burst, latency 1 clamps to 2
        start_burst(16'h0020, 6, 0); idle(3);
        start_burst(16'h003E, 1, 1); idle(10);
        // long slow burst crossing two windows
        start_burst(16'h0030, 2, 1); idle(150);
        checking = 0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule